// File: doc/BRIEF.md
# Overlapping 0101 Pattern Detector with Occurrence Counter

The block reads a serial bit stream, one bit on every rising clock edge, and looks for the four-bit pattern 0 then 1 then 0 then 1 in arrival order. A five-state Moore machine tracks how much of the pattern has arrived. Its detect flag comes from the state register alone, so the flag is high for the single cycle after the bit that completes a match. Matches may overlap: the trailing "01" of one match can start the next one, so the stream 0,1,0,1,0,1 gives two detections.

Each detection increments a binary occurrence counter in the same clock edge that raises the flag. The counter wraps around to zero when it passes its maximum. Each four-bit group of the count drives one active-low seven-segment digit showing the nibble in hexadecimal. The bit stream is a plain input with no handshake. A new bit is consumed on every clock, so the source has no way to apply back-pressure and must present a meaningful bit on every cycle.

Top module: `pat_count_top`

## Requirements
- R1: While rst_n is low, and without waiting for a clock edge, detect is 0 and count is 0. The machine returns to the state in which no pattern bits have been received.
- R2: detect is 1 in the cycle after the rising edge that captured a bit completing the ordered sequence 0,1,0,1. At least four bits must have been captured since reset. detect is 0 in every other cycle.
- R3: Matches overlap. After a match, the last two bits (0,1) count as the first half of the next match, so each further "01" pair yields another detection. A 1 received right after a match restarts the search from nothing.
- R4: count increments by one on exactly the rising edge where detect becomes 1. On every other edge it holds its value.
- R5: count is COUNT_W bits wide (default 8) and wraps from its maximum value (FF by default) to 0 on the next detection.
- R6: seg_n[7*k+6 : 7*k] shows nibble k of count, with nibble 0 the least significant. The bit order inside each group is {g,f,e,d,c,b,a}, and a segment is lit when its bit is 0. The active-high lit masks for hex digits 0 to F are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71. Each output group is the bitwise inverse of its mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one stream bit per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial stream bit |
| detect | output | 1 | Moore match flag, high for one cycle per match |
| count | output | COUNT_W | Wrap-around number of matches |
| seg_n | output | 7*ceil(COUNT_W/4) | Active-low seven-segment patterns, digit 0 in the low bits |

## Verification
The hardest situations to reach from the ports are the wrap of the counter and long runs of overlapping matches. A wrap needs 256 matches without a reset in between. The stimulus feeds a continuous run of "01" pairs, which gives a new match every two cycles, and keeps going past the wrap. The machine's transitions are covered by an exhaustive sweep of every ten-bit stream that follows a reset. Expected flags and counts come from a shift-history model of the last four bits.

// File: rtl/pat_count_pkg.sv
package pat_count_pkg;

  typedef enum logic [2:0] {
    ST_NONE = 3'd0,
    ST_Z    = 3'd1,
    ST_ZO   = 3'd2,
    ST_ZOZ  = 3'd3,
    ST_HIT  = 3'd4
  } pstate_e;

  localparam int SEG_W = 7;
  localparam int NIB_W = 4;

  // active-high lit mask, bit order {g,f,e,d,c,b,a}
  function automatic logic [SEG_W-1:0] hex_mask(input logic [NIB_W-1:0] v);
    logic [SEG_W-1:0] m;
    case (v)
      4'h0: m = 7'h3F;
      4'h1: m = 7'h06;
      4'h2: m = 7'h5B;
      4'h3: m = 7'h4F;
      4'h4: m = 7'h66;
      4'h5: m = 7'h6D;
      4'h6: m = 7'h7D;
      4'h7: m = 7'h07;
      4'h8: m = 7'h7F;
      4'h9: m = 7'h6F;
      4'hA: m = 7'h77;
      4'hB: m = 7'h7C;
      4'hC: m = 7'h39;
      4'hD: m = 7'h5E;
      4'hE: m = 7'h79;
      default: m = 7'h71;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pat_fsm.sv
module pat_fsm
  import pat_count_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic detect,
  output logic hit_next
);

  pstate_e state_q;
  pstate_e state_d;

  always_comb begin
    case (state_q)
      ST_NONE: state_d = din ? ST_NONE : ST_Z;
      ST_Z:    state_d = din ? ST_ZO   : ST_Z;
      ST_ZO:   state_d = din ? ST_NONE : ST_ZOZ;
      ST_ZOZ:  state_d = din ? ST_HIT  : ST_Z;
      ST_HIT:  state_d = din ? ST_NONE : ST_ZOZ;
      default: state_d = ST_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_NONE;
    else        state_q <= state_d;
  end

  assign detect   = (state_q == ST_HIT);
  assign hit_next = (state_d == ST_HIT);

  // R2: a match always closes on a 1
  a_r2_ends_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    detect |-> $past(din));

  // R3: overlapping matches are at least two cycles apart
  a_r3_gap_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    detect |=> !detect);

endmodule

// File: rtl/pat_counter.sv
module pat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/pat_seg_digit.sv
module pat_seg_digit
  import pat_count_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output logic [SEG_W-1:0] seg_n
);

  assign seg_n = ~hex_mask(nib);

  // R6: every hex glyph lights at least two segments
  always_comb begin
    a_r6_glyph_lit: assert ($countones(~seg_n) >= 2);
  end

endmodule

// File: rtl/pat_count_top.sv
module pat_count_top
  import pat_count_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                din,
  output logic                                detect,
  output logic [COUNT_W-1:0]                  count,
  output logic [((COUNT_W+3)/4)*SEG_W-1:0]    seg_n
);

  localparam int NDIG  = (COUNT_W + NIB_W - 1) / NIB_W;
  localparam int PAD_W = NDIG * NIB_W;

  logic             hit_next;
  logic [PAD_W-1:0] count_pad;

  pat_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .detect   (detect),
    .hit_next (hit_next)
  );

  pat_counter #(.W(COUNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (hit_next),
    .cnt   (count)
  );

  assign count_pad = PAD_W'(count);

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    pat_seg_digit u_dig (
      .nib   (count_pad[k*NIB_W +: NIB_W]),
      .seg_n (seg_n[k*SEG_W +: SEG_W])
    );
  end

  // R4: the count steps exactly when the flag is raised
  a_r4_step_on_detect: assert property (@(posedge clk) disable iff (!rst_n)
    detect |-> (count == $past(count) + COUNT_W'(1)));

  a_r4_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !detect |-> $stable(count));

endmodule

// File: tb/sim_pat_count_top.sv
module sim_pat_count_top;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          din = 1'b0;
  logic          detect;
  logic [CW-1:0] count;
  logic [13:0]   seg_n;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0]    hist;
  int            nbits;
  logic [CW-1:0] exp_cnt;

  always #2 clk = ~clk;

  pat_count_top #(.COUNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din),
    .detect(detect), .count(count), .seg_n(seg_n)
  );

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    logic [6:0] lit;
    case (v)
      4'h0: lit = 7'h3F; 4'h1: lit = 7'h06; 4'h2: lit = 7'h5B; 4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66; 4'h5: lit = 7'h6D; 4'h6: lit = 7'h7D; 4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F; 4'h9: lit = 7'h6F; 4'hA: lit = 7'h77; 4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39; 4'hD: lit = 7'h5E; 4'hE: lit = 7'h79; default: lit = 7'h71;
    endcase
    return ~lit;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check_outputs(input string tagd);
    chk(tagd, {31'd0, detect}, {31'd0, (nbits >= 4 && hist == 4'b0101)});
    chk("R4 count", {24'd0, count}, {24'd0, exp_cnt});
    chk("R6 seg lo", {25'd0, seg_n[6:0]}, {25'd0, exp_seg(exp_cnt[3:0])});
    chk("R6 seg hi", {25'd0, seg_n[13:7]}, {25'd0, exp_seg(exp_cnt[7:4])});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk("R1 reset detect", {31'd0, detect}, 32'd0);
    chk("R1 reset count", {24'd0, count}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    hist = 4'd0;
    nbits = 0;
    exp_cnt = '0;
  endtask

  // drive at negedge, capture at posedge, check at next negedge
  task automatic feed(input logic b, input string tagd);
    din = b;
    @(posedge clk);
    @(negedge clk);
    hist = {hist[2:0], b};
    nbits++;
    if (nbits >= 4 && hist == 4'b0101) exp_cnt = exp_cnt + 8'd1;
    check_outputs(tagd);
  endtask

  initial begin
    #700000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    hist = 4'd0;
    nbits = 0;
    exp_cnt = '0;
    @(negedge clk);
    do_reset();
    check_outputs("R1 R2 idle");

    // exhaustive ten-bit streams after reset
    for (int s = 0; s < 1024; s++) begin
      do_reset();
      for (int i = 9; i >= 0; i--) feed(s[i], "R2 R3 detect sweep");
    end

    // long overlapping run through counter wrap
    do_reset();
    for (int p = 0; p < 258; p++) begin
      feed(1'b0, "R3 overlap");
      feed(1'b1, "R3 overlap");
      if (p == 256) chk("R5 wrap to zero", {24'd0, count}, 32'd0);
    end
    chk("R5 after wrap", {24'd0, count}, 32'd1);

    // a 1 after a match restarts the search
    feed(1'b1, "R3 restart");
    feed(1'b0, "R3 restart");
    feed(1'b1, "R3 restart");
    chk("R3 no false hit", {31'd0, detect}, 32'd0);

    // asynchronous reset mid-cycle
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 async count", {24'd0, count}, 32'd0);
    chk("R1 async detect", {31'd0, detect}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    hist = 4'd0;
    nbits = 0;
    exp_cnt = '0;
    feed(1'b1, "R1 post reset");
    feed(1'b0, "R1 post reset");
    feed(1'b1, "R1 post reset");
    chk("R1 no memory", {31'd0, detect}, 32'd0);

    finish_run();
  end

endmodule